// File: doc/BRIEF.md
# Two-Wire Master Register and Interrupt Front End

This block is the memory-mapped control face of a push-pull two-wire serial master. Software reaches it over a plain 32-bit register bus (select, write enable, byte address, write data, combinational read data). It stores the serial clock setup, the transfer length and direction, two address bytes, two data bytes, a free-form mode word and the line-override settings, and drives all of them straight to the serial engine that sits outside this block.

A transfer begins when software sets the start bit in the control word. The front end then sends one start pulse to the engine and reports itself busy through that same bit until the engine signals done. A start written while a transfer is running is refused and flagged. Done, error and refused-start events are captured in write-one-to-clear status bits, together with an error code from the engine. An interrupt line rises when an enabled status bit is set and the global interrupt enable is on. A soft-reset bit returns every register to its reset state, and an abort bit drops a running transfer.

Top module: `tw_reg_front`

## Requirements
- R1: After reset every register reads 0 (apart from the live line levels in bits 5 and 4 of the line word), the interrupt is low and no start or abort pulse is driven.
- R2: Word offsets: control 0x00, clock 0x04, interrupt enable 0x08, status 0x0C, address bytes 0x10 and 0x14, length 0x18, data bytes 0x1C and 0x20, line word 0x24, mode word 0x28. Clock keeps divider [7:0] and SDA delay [10:8]; length keeps direction bit 4 (1 = read) and count-minus-one [2:0]; byte registers keep [7:0]; the mode word keeps all 32 bits; other bits read 0, every value reaches the engine outputs, and writes to unaligned or unmapped addresses change nothing.
- R3: Writing control with bit 7 set while idle drives eng_start high for exactly the next cycle, and control bit 7 then reads 1 until the engine reports done.
- R4: Writing control bit 7 while busy launches nothing and sets status bit 2.
- R5: eng_done while busy clears control bit 7 and sets status bit 0; eng_done while idle changes no status bit.
- R6: eng_done with eng_err while busy also sets status bit 1 and stores eng_err_id in status [15:8]; data byte 0 is left unchanged.
- R7: A successful read transfer (length bit 4 = 1) loads eng_rdata into data byte 0 at done.
- R8: Writing 1 to status bits 0, 1 or 2 clears them, writing 0 has no effect, the error code is cleared with bit 1, and an event in the same cycle as a clear wins.
- R9: irq is high exactly when control bit 1 (global enable) is 1 and some status bit [2:0] is set whose enable bit [2:0] is also 1.
- R10: Line word bits 0/1 are the SDA override enable/value and bits 2/3 the SCL override enable/value, driven on the override outputs; bits 4 and 5 read the live SDA and SCL levels.
- R11: Writing control bit 0 makes it read 1 for one cycle, after which all registers and the busy state are back at their reset values; the other bits of that write are ignored.
- R12: Writing control bit 6 (without bit 7) while busy drives eng_abort for one cycle and clears busy without setting any status bit; a later eng_done is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| eng_done | input | 1 | Engine reports transfer end |
| eng_err | input | 1 | Qualifies eng_done as failed |
| eng_err_id | input | 8 | Error code from the engine |
| eng_rdata | input | 8 | Received byte from the engine |
| eng_clk_div | output | 8 | Serial clock divider |
| eng_sda_dly | output | 3 | SDA output delay |
| eng_rd | output | 1 | Transfer direction (1 = read) |
| eng_len | output | 3 | Byte count minus one |
| eng_adr0 | output | 8 | Address byte 0 |
| eng_adr1 | output | 8 | Address byte 1 |
| eng_wdata0 | output | 8 | Data byte 0 |
| eng_wdata1 | output | 8 | Data byte 1 |
| eng_mode | output | 32 | Mode word |
| sda_in | input | 1 | Live SDA level |
| scl_in | input | 1 | Live SCL level |
| sda_ovr_en | output | 1 | SDA override enable |
| sda_ovr_val | output | 1 | SDA override value |
| scl_ovr_en | output | 1 | SCL override enable |
| scl_ovr_val | output | 1 | SCL override value |

## Verification
The assertions watch on every cycle that the start and abort pulses last one cycle and occur only around a busy transfer, that done always clears busy and sets the done flag, that a refused start is the only way the load-busy flag rises, that the interrupt never fires without a status bit, that the error code is empty whenever the error flag is clear, and that soft reset lasts one cycle and empties busy and status. Field layout and masking of each register, the received byte landing in data byte 0, priority of events over clears, the interrupt masking combinations and the live line read-back can only be shown by the bench's scenarios through the register bus.

// File: rtl/tw_pkg.sv
package tw_pkg;

    parameter int BUS_W  = 32;
    parameter int BYTE_W = 8;
    parameter int DIV_W  = 8;
    parameter int DLY_W  = 3;
    parameter int LEN_W  = 3;
    parameter int NSTAT  = 3;
    parameter int NBYTE  = 4;

    // word index = byte address [5:2]
    typedef enum logic [3:0] {
        W_CTRL = 4'd0,
        W_CLK  = 4'd1,
        W_IEN  = 4'd2,
        W_STAT = 4'd3,
        W_ADR0 = 4'd4,
        W_ADR1 = 4'd5,
        W_LEN  = 4'd6,
        W_DAT0 = 4'd7,
        W_DAT1 = 4'd8,
        W_LINE = 4'd9,
        W_MODE = 4'd10
    } word_e;

    // control bits
    localparam int CB_START = 7;
    localparam int CB_ABORT = 6;
    localparam int CB_GIE   = 1;
    localparam int CB_SRST  = 0;

    // status bits
    localparam int SB_DONE  = 0;
    localparam int SB_ERR   = 1;
    localparam int SB_LB    = 2;
    localparam int SB_ID_LO = 8;

    // other field positions
    localparam int CLK_DLY_LO = 8;
    localparam int LEN_RD_BIT = 4;
    localparam int LN_SDA_EN  = 0;
    localparam int LN_SDA_VAL = 1;
    localparam int LN_SCL_EN  = 2;
    localparam int LN_SCL_VAL = 3;
    localparam int LN_SDA_LIV = 4;
    localparam int LN_SCL_LIV = 5;

    // byte register slot that receives read data
    localparam int RX_SLOT = 2;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DLY_W-1:0]  dly;
        logic              rd;
        logic [LEN_W-1:0]  len;
        logic [BYTE_W-1:0] adr0;
        logic [BYTE_W-1:0] adr1;
        logic [BYTE_W-1:0] dat0;
        logic [BYTE_W-1:0] dat1;
        logic              sda_en;
        logic              sda_val;
        logic              scl_en;
        logic              scl_val;
        logic [BUS_W-1:0]  mode;
    } cfg_t;

    typedef struct packed {
        logic              lb;
        logic              err;
        logic              fin;
        logic [BYTE_W-1:0] id;
    } evt_t;

    function automatic word_e slot_word(input int slot);
        case (slot)
            0:       return W_ADR0;
            1:       return W_ADR1;
            2:       return W_DAT0;
            default: return W_DAT1;
        endcase
    endfunction

endpackage

// File: rtl/tw_cfg_regs.sv
module tw_cfg_regs
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              we,
    input  word_e             wsel,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    output cfg_t              cfg
);

    logic [DIV_W-1:0]             div_q;
    logic [DLY_W-1:0]             dly_q;
    logic                         rd_q;
    logic [LEN_W-1:0]             len_q;
    logic [3:0]                   line_q;
    logic [BUS_W-1:0]             mode_q;
    logic [NBYTE-1:0][BYTE_W-1:0] bvec;

    always_ff @(posedge clk) begin
        if (clr) begin
            div_q  <= '0;
            dly_q  <= '0;
            rd_q   <= 1'b0;
            len_q  <= '0;
            line_q <= '0;
            mode_q <= '0;
        end else if (we) begin
            case (wsel)
                W_CLK: begin
                    div_q <= wdata[DIV_W-1:0];
                    dly_q <= wdata[CLK_DLY_LO +: DLY_W];
                end
                W_LEN: begin
                    rd_q  <= wdata[LEN_RD_BIT];
                    len_q <= wdata[LEN_W-1:0];
                end
                W_LINE: line_q <= wdata[LN_SCL_VAL:LN_SDA_EN];
                W_MODE: mode_q <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        localparam word_e MYW = slot_word(g);
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (clr) begin
                q <= '0;
            end else if ((g == RX_SLOT) && rx_load) begin
                q <= rx_byte;
            end else if (we && (wsel == MYW)) begin
                q <= wdata[BYTE_W-1:0];
            end
        end
        assign bvec[g] = q;
    end

    always_comb begin
        cfg         = '0;
        cfg.div     = div_q;
        cfg.dly     = dly_q;
        cfg.rd      = rd_q;
        cfg.len     = len_q;
        cfg.adr0    = bvec[0];
        cfg.adr1    = bvec[1];
        cfg.dat0    = bvec[2];
        cfg.dat1    = bvec[3];
        cfg.sda_en  = line_q[LN_SDA_EN];
        cfg.sda_val = line_q[LN_SDA_VAL];
        cfg.scl_en  = line_q[LN_SCL_EN];
        cfg.scl_val = line_q[LN_SCL_VAL];
        cfg.mode    = mode_q;
    end

endmodule

// File: rtl/tw_xfer_ctl.sv
module tw_xfer_ctl
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              w_start,
    input  logic              w_abort,
    input  logic              w_gie,
    input  logic              w_srst,
    input  logic              rd_mode,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [BYTE_W-1:0] eng_err_id,
    output logic              busy,
    output logic              gie,
    output logic              srst,
    output logic              eng_start,
    output logic              eng_abort,
    output logic              rx_load,
    output evt_t              evt
);

    logic ctl_ok;
    logic fin;

    // a soft-reset request masks the rest of the same write
    assign ctl_ok = ctrl_wr && !w_srst && !srst;
    assign fin    = busy && eng_done && !srst;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst <= 1'b0;
        end else begin
            srst <= ctrl_wr && w_srst && !srst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            busy      <= 1'b0;
            gie       <= 1'b0;
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
            if (fin) begin
                busy <= 1'b0;
            end
            if (ctl_ok) begin
                gie <= w_gie;
                if (w_start && !busy) begin
                    busy      <= 1'b1;
                    eng_start <= 1'b1;
                end else if (!w_start && w_abort && busy) begin
                    busy      <= 1'b0;
                    eng_abort <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        evt     = '0;
        evt.fin = fin;
        evt.err = fin && eng_err;
        evt.id  = eng_err_id;
        evt.lb  = ctl_ok && w_start && busy;
        rx_load = fin && !eng_err && rd_mode;
    end

endmodule

// File: rtl/tw_irq_status.sv
module tw_irq_status
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              stat_wr,
    input  logic              ien_wr,
    input  logic [NSTAT-1:0]  w_bits,
    input  evt_t              evt,
    input  logic              gie,
    output logic [NSTAT-1:0]  stat,
    output logic [NSTAT-1:0]  ien,
    output logic [BYTE_W-1:0] err_id,
    output logic              irq
);

    logic [NSTAT-1:0] set_v;

    always_comb begin
        set_v         = '0;
        set_v[SB_DONE] = evt.fin;
        set_v[SB_ERR]  = evt.err;
        set_v[SB_LB]   = evt.lb;
    end

    for (genvar b = 0; b < NSTAT; b++) begin : g_stat
        always_ff @(posedge clk) begin
            if (clr) begin
                stat[b] <= 1'b0;
            end else if (set_v[b]) begin
                stat[b] <= 1'b1;
            end else if (stat_wr && w_bits[b]) begin
                stat[b] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            err_id <= '0;
        end else if (evt.err) begin
            err_id <= evt.id;
        end else if (stat_wr && w_bits[SB_ERR]) begin
            err_id <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            ien <= '0;
        end else if (ien_wr) begin
            ien <= w_bits;
        end
    end

    assign irq = gie && |(stat & ien);

endmodule

// File: rtl/tw_reg_front.sv
module tw_reg_front
    import tw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              eng_start,
    output logic              eng_abort,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [7:0]        eng_err_id,
    input  logic [7:0]        eng_rdata,
    output logic [7:0]        eng_clk_div,
    output logic [2:0]        eng_sda_dly,
    output logic              eng_rd,
    output logic [2:0]        eng_len,
    output logic [7:0]        eng_adr0,
    output logic [7:0]        eng_adr1,
    output logic [7:0]        eng_wdata0,
    output logic [7:0]        eng_wdata1,
    output logic [31:0]       eng_mode,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_ovr_en,
    output logic              sda_ovr_val,
    output logic              scl_ovr_en,
    output logic              scl_ovr_val
);

    localparam int WORD_HI = 5;

    logic              hit;
    logic              wr;
    word_e             wsel;
    logic              busy_w;
    logic              gie_w;
    logic              srst_w;
    logic              clr_w;
    logic              rx_load_w;
    evt_t              evt_w;
    cfg_t              cfg_w;
    logic [NSTAT-1:0]  stat_w;
    logic [NSTAT-1:0]  ien_w;
    logic [BYTE_W-1:0] err_id_w;

    // aligned, inside the 16-word window
    always_comb begin
        hit = (bus_addr[1:0] == 2'b00);
        if (ADDR_W > WORD_HI + 1) begin
            hit = hit && ((bus_addr >> (WORD_HI + 1)) == '0);
        end
    end

    assign wsel  = word_e'(bus_addr[WORD_HI:2]);
    assign wr    = bus_sel && bus_we && hit;
    assign clr_w = rst || srst_w;

    tw_xfer_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (wr && (wsel == W_CTRL)),
        .w_start    (bus_wdata[CB_START]),
        .w_abort    (bus_wdata[CB_ABORT]),
        .w_gie      (bus_wdata[CB_GIE]),
        .w_srst     (bus_wdata[CB_SRST]),
        .rd_mode    (cfg_w.rd),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .eng_err_id (eng_err_id),
        .busy       (busy_w),
        .gie        (gie_w),
        .srst       (srst_w),
        .eng_start  (eng_start),
        .eng_abort  (eng_abort),
        .rx_load    (rx_load_w),
        .evt        (evt_w)
    );

    tw_cfg_regs u_cfg (
        .clk     (clk),
        .clr     (clr_w),
        .we      (wr),
        .wsel    (wsel),
        .wdata   (bus_wdata),
        .rx_load (rx_load_w),
        .rx_byte (eng_rdata),
        .cfg     (cfg_w)
    );

    tw_irq_status u_irq (
        .clk     (clk),
        .clr     (clr_w),
        .stat_wr (wr && (wsel == W_STAT)),
        .ien_wr  (wr && (wsel == W_IEN)),
        .w_bits  (bus_wdata[NSTAT-1:0]),
        .evt     (evt_w),
        .gie     (gie_w),
        .stat    (stat_w),
        .ien     (ien_w),
        .err_id  (err_id_w),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (wsel)
                W_CTRL: begin
                    bus_rdata[CB_START] = busy_w;
                    bus_rdata[CB_GIE]   = gie_w;
                    bus_rdata[CB_SRST]  = srst_w;
                end
                W_CLK: begin
                    bus_rdata[DIV_W-1:0]           = cfg_w.div;
                    bus_rdata[CLK_DLY_LO +: DLY_W] = cfg_w.dly;
                end
                W_IEN:  bus_rdata[NSTAT-1:0] = ien_w;
                W_STAT: begin
                    bus_rdata[NSTAT-1:0]         = stat_w;
                    bus_rdata[SB_ID_LO +: BYTE_W] = err_id_w;
                end
                W_ADR0: bus_rdata[BYTE_W-1:0] = cfg_w.adr0;
                W_ADR1: bus_rdata[BYTE_W-1:0] = cfg_w.adr1;
                W_LEN: begin
                    bus_rdata[LEN_RD_BIT] = cfg_w.rd;
                    bus_rdata[LEN_W-1:0]  = cfg_w.len;
                end
                W_DAT0: bus_rdata[BYTE_W-1:0] = cfg_w.dat0;
                W_DAT1: bus_rdata[BYTE_W-1:0] = cfg_w.dat1;
                W_LINE: begin
                    bus_rdata[LN_SDA_EN]  = cfg_w.sda_en;
                    bus_rdata[LN_SDA_VAL] = cfg_w.sda_val;
                    bus_rdata[LN_SCL_EN]  = cfg_w.scl_en;
                    bus_rdata[LN_SCL_VAL] = cfg_w.scl_val;
                    bus_rdata[LN_SDA_LIV] = sda_in;
                    bus_rdata[LN_SCL_LIV] = scl_in;
                end
                W_MODE: bus_rdata = cfg_w.mode;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign eng_clk_div = cfg_w.div;
    assign eng_sda_dly = cfg_w.dly;
    assign eng_rd      = cfg_w.rd;
    assign eng_len     = cfg_w.len;
    assign eng_adr0    = cfg_w.adr0;
    assign eng_adr1    = cfg_w.adr1;
    assign eng_wdata0  = cfg_w.dat0;
    assign eng_wdata1  = cfg_w.dat1;
    assign eng_mode    = cfg_w.mode;
    assign sda_ovr_en  = cfg_w.sda_en;
    assign sda_ovr_val = cfg_w.sda_val;
    assign scl_ovr_en  = cfg_w.scl_en;
    assign scl_ovr_val = cfg_w.scl_val;

endmodule

// File: rtl/tw_reg_front_chk.sv
module tw_reg_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       eng_start,
    input logic       eng_abort,
    input logic       eng_done,
    input logic       busy,
    input logic       srst,
    input logic       irq,
    input logic [2:0] stat,
    input logic [7:0] err_id
);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R3

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy); // R3

    AST_LB_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[2]) |-> $past(busy)); // R4

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_done) |=> !busy); // R5

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_done && !srst) |=> stat[0]); // R5

    AST_ID_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst)
        !stat[1] |-> (err_id == 8'd0)); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat != 3'd0)); // R9

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!srst && !busy && (stat == 3'd0))); // R11

    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_abort |=> (!eng_abort && !busy)); // R12

endmodule

bind tw_reg_front tw_reg_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .eng_start (eng_start),
    .eng_abort (eng_abort),
    .eng_done  (eng_done),
    .busy      (busy_w),
    .srst      (srst_w),
    .irq       (irq),
    .stat      (stat_w),
    .err_id    (err_id_w)
);

// File: tb/tw_reg_front_tb_top.sv
module tw_reg_front_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start, eng_abort;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [7:0]  eng_err_id = '0;
    logic [7:0]  eng_rdata = '0;
    logic [7:0]  eng_clk_div, eng_adr0, eng_adr1, eng_wdata0, eng_wdata1;
    logic [2:0]  eng_sda_dly, eng_len;
    logic        eng_rd;
    logic [31:0] eng_mode;
    logic        sda_in = 1'b1;
    logic        scl_in = 1'b0;
    logic        sda_ovr_en, sda_ovr_val, scl_ovr_en, scl_ovr_val;

    always #4 clk = ~clk;

    tw_reg_front dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_done(eng_done), .eng_err(eng_err), .eng_err_id(eng_err_id),
        .eng_rdata(eng_rdata), .eng_clk_div(eng_clk_div),
        .eng_sda_dly(eng_sda_dly), .eng_rd(eng_rd), .eng_len(eng_len),
        .eng_adr0(eng_adr0), .eng_adr1(eng_adr1), .eng_wdata0(eng_wdata0),
        .eng_wdata1(eng_wdata1), .eng_mode(eng_mode), .sda_in(sda_in),
        .scl_in(scl_in), .sda_ovr_en(sda_ovr_en), .sda_ovr_val(sda_ovr_val),
        .scl_ovr_en(scl_ovr_en), .scl_ovr_val(scl_ovr_val)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    task automatic check(input logic [31:0] got, input logic [31:0] exp,
                         input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected read item per cycle in which one is queued
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e,
                          input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic eng_finish(input logic err, input logic [7:0] id,
                              input logic [7:0] rb);
        @(negedge clk);
        eng_done = 1'b1; eng_err = err; eng_err_id = id; eng_rdata = rb;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0; eng_err_id = '0; eng_rdata = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check({31'd0, irq}, 32'd0, "R1 irq");
        check({31'd0, eng_start}, 32'd0, "R1 eng_start");
        check({31'd0, eng_abort}, 32'd0, "R1 eng_abort");
        rd_exp(8'h00, 32'h0, "R1 ctrl");
        rd_exp(8'h04, 32'h0, "R1 clock");
        rd_exp(8'h08, 32'h0, "R1 enable");
        rd_exp(8'h0C, 32'h0, "R1 status");
        rd_exp(8'h10, 32'h0, "R1 adr0");
        rd_exp(8'h18, 32'h0, "R1 length");
        rd_exp(8'h1C, 32'h0, "R1 data0");
        rd_exp(8'h28, 32'h0, "R1 mode");
        rd_exp(8'h24, 32'h10, "R10 live levels after reset");

        // R2 field masking and engine outputs
        wr(8'h04, 32'hFFFF_FFFF);
        rd_exp(8'h04, 32'h0000_07FF, "R2 clock mask");
        wr(8'h18, 32'hFFFF_FFFF);
        rd_exp(8'h18, 32'h0000_0017, "R2 length mask");
        wr(8'h10, 32'h1234_56A5);
        rd_exp(8'h10, 32'h0000_00A5, "R2 adr0");
        wr(8'h14, 32'h0000_003C);
        rd_exp(8'h14, 32'h0000_003C, "R2 adr1");
        wr(8'h1C, 32'hFFFF_FF5A);
        rd_exp(8'h1C, 32'h0000_005A, "R2 data0");
        wr(8'h20, 32'h0000_00C3);
        rd_exp(8'h20, 32'h0000_00C3, "R2 data1");
        wr(8'h28, 32'hDEAD_BEEF);
        rd_exp(8'h28, 32'hDEAD_BEEF, "R2 mode");
        #1;
        check({24'd0, eng_clk_div}, 32'hFF, "R2 eng_clk_div");
        check({29'd0, eng_sda_dly}, 32'h7, "R2 eng_sda_dly");
        check({28'd0, eng_rd, eng_len}, 32'hF, "R2 eng_rd/eng_len");
        check({eng_adr0, eng_adr1, eng_wdata0, eng_wdata1}, 32'hA53C_5AC3,
              "R2 byte outputs");
        check(eng_mode, 32'hDEAD_BEEF, "R2 eng_mode");
        wr(8'h05, 32'h0);
        rd_exp(8'h04, 32'h0000_07FF, "R2 unaligned write ignored");
        wr(8'h44, 32'hFFFF_FFFF);
        rd_exp(8'h04, 32'h0000_07FF, "R2 unmapped write ignored");
        rd_exp(8'h2C, 32'h0, "R2 unmapped read");

        // R10 line override
        wr(8'h24, 32'hFFFF_FFFF);
        rd_exp(8'h24, 32'h1F, "R10 override all set");
        #1;
        check({28'd0, scl_ovr_val, scl_ovr_en, sda_ovr_val, sda_ovr_en},
              32'hF, "R10 override outputs");
        sda_in = 1'b0; scl_in = 1'b1;
        wr(8'h24, 32'h5);
        rd_exp(8'h24, 32'h25, "R10 live swap");
        #1;
        check({28'd0, scl_ovr_val, scl_ovr_en, sda_ovr_val, sda_ovr_en},
              32'h5, "R10 enable without value");
        wr(8'h24, 32'h0);

        // R3 launch
        wr(8'h18, 32'h0);
        wr(8'h08, 32'h7);
        wr(8'h00, 32'h82);
        #1;
        check({31'd0, eng_start}, 32'd1, "R3 start pulse");
        rd_exp(8'h00, 32'h82, "R3 busy reads back");
        #1;
        check({31'd0, eng_start}, 32'd0, "R3 pulse one cycle");
        check({31'd0, irq}, 32'd0, "R9 no flag no irq");

        // R4 start while busy
        wr(8'h00, 32'h82);
        #1;
        check({31'd0, eng_start}, 32'd0, "R4 no relaunch");
        rd_exp(8'h0C, 32'h4, "R4 load busy flag");
        #1;
        check({31'd0, irq}, 32'd1, "R9 irq on flag");

        // R5 done
        eng_finish(1'b0, 8'h00, 8'h00);
        rd_exp(8'h0C, 32'h5, "R5 done flag");
        rd_exp(8'h00, 32'h02, "R5 busy cleared");

        // R8 write-one-to-clear
        wr(8'h0C, 32'h4);
        rd_exp(8'h0C, 32'h1, "R8 clear bit2 only");
        wr(8'h0C, 32'h0);
        rd_exp(8'h0C, 32'h1, "R8 zero write no effect");
        wr(8'h0C, 32'h1);
        rd_exp(8'h0C, 32'h0, "R8 clear bit0");
        #1;
        check({31'd0, irq}, 32'd0, "R9 irq drops");

        // R5 done while idle ignored
        eng_finish(1'b0, 8'h00, 8'h77);
        rd_exp(8'h0C, 32'h0, "R5 idle done ignored");
        rd_exp(8'h1C, 32'h5A, "R7 idle done keeps data0");

        // R7 read transfer
        wr(8'h18, 32'h10);
        wr(8'h00, 32'h82);
        eng_finish(1'b0, 8'h00, 8'h9E);
        rd_exp(8'h1C, 32'h9E, "R7 received byte");
        wr(8'h0C, 32'h7);

        // R6 error
        wr(8'h00, 32'h82);
        eng_finish(1'b1, 8'h03, 8'h44);
        rd_exp(8'h0C, 32'h0303, "R6 error flag and code");
        rd_exp(8'h1C, 32'h9E, "R6 data0 unchanged");
        wr(8'h0C, 32'h2);
        rd_exp(8'h0C, 32'h1, "R8 code cleared with bit1");
        wr(8'h0C, 32'h1);

        // R8 event beats clear in the same cycle
        wr(8'h00, 32'h82);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1;
        eng_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; eng_done = 1'b0;
        rd_exp(8'h0C, 32'h1, "R8 set wins over clear");
        wr(8'h0C, 32'h7);

        // R9 masking
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h82);
        eng_finish(1'b0, 8'h00, 8'h00);
        #1;
        check({31'd0, irq}, 32'd1, "R9 enabled flag");
        wr(8'h00, 32'h00);
        #1;
        check({31'd0, irq}, 32'd0, "R9 global off");
        wr(8'h08, 32'h2);
        wr(8'h00, 32'h02);
        #1;
        check({31'd0, irq}, 32'd0, "R9 flag masked");
        wr(8'h0C, 32'h7);

        // R12 abort
        wr(8'h00, 32'h82);
        wr(8'h00, 32'h42);
        #1;
        check({31'd0, eng_abort}, 32'd1, "R12 abort pulse");
        rd_exp(8'h00, 32'h02, "R12 busy cleared");
        #1;
        check({31'd0, eng_abort}, 32'd0, "R12 pulse one cycle");
        rd_exp(8'h0C, 32'h0, "R12 no flag");
        eng_finish(1'b0, 8'h00, 8'h00);
        rd_exp(8'h0C, 32'h0, "R12 late done ignored");

        // R11 soft reset
        wr(8'h04, 32'h1AB);
        wr(8'h00, 32'h82);
        wr(8'h00, 32'h81);
        #2;
        check(bus_rdata, 32'h83, "R11 reset bit visible");
        rd_exp(8'h00, 32'h0, "R11 ctrl cleared");
        rd_exp(8'h04, 32'h0, "R11 clock cleared");
        rd_exp(8'h08, 32'h0, "R11 enable cleared");
        rd_exp(8'h28, 32'h0, "R11 mode cleared");
        #1;
        check({31'd0, eng_start}, 32'd0, "R11 no launch");

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule